// File: doc/BRIEF.md
# Sample Acquisition Sequencer

This block runs a single capture of 8-bit samples into a word-wide buffer memory. While it is idle, the host loads three values: a word address where storage begins, a sample count, and a post-trigger delay in samples. The host then arms the block. Once armed, the sequencer waits for a trigger-accepted pulse. It then throws away the delay's worth of valid samples and packs each later pair of samples into one 16-bit memory write. The write address advances by one for each word. When the count is used up, the sequencer raises an interrupt and holds it until the host clears it. After the clear it returns to idle.

The sample count and the delay are both rounded up to an even number of samples, so only whole words are ever stored. The host may touch the buffer only while the block is idle, and a status line marks that window. A second status line stays high from reset until the first register write. It tells the host that nothing has been configured yet.

Top module: `acq_seq`

## Requirements
- R1: After reset, busy_o=0, irq_o=0, mem_we_o=0, host_mem_en_o=1 and unconfig_o=1. unconfig_o falls in the cycle after the first reg_we_i and never rises again.
- R2: A write with reg_we_i=1 loads a register chosen by reg_sel_i: 0 loads the start word address, 1 loads the length in samples, 2 loads the post-trigger delay in samples, and 3 has no effect. A write made while busy_o=1 is ignored.
- R3: arm_i while idle sets busy_o=1 in the next cycle. arm_i while busy has no effect. trig_i is accepted only while armed and is ignored otherwise. If a register write and arm_i fall in the same cycle, the capture uses the newly written value.
- R4: After the trigger cycle, the first 2*ceil(D/2) valid samples are discarded, where D is the delay. A sample presented in the trigger cycle itself is not counted.
- R5: Of each pair of kept samples, the first goes to mem_wdata_o[7:0] and the second to mem_wdata_o[15:8]. mem_we_o pulses for one cycle, in the cycle after the second sample's valid cycle.
- R6: A capture with length L performs exactly ceil(L/2) writes and then consumes no more samples. L=0 performs no write.
- R7: The first word goes to the start address. Each later word goes to the previous address plus one, modulo 2^ADDR_W.
- R8: irq_o rises in the same cycle as the final write, or when the delay ends if L=0. It stays high, with samples ignored, until irq_clr_i. The block is idle in the cycle after the clear. irq_clr_i in any other state has no effect.
- R9: host_mem_en_o=1 exactly when the block is idle, and busy_o is its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 start, 1 length, 2 delay |
| reg_wdata_i | input | max(ADDR_W,CNT_W) | Register write value |
| arm_i | input | 1 | Arm request |
| trig_i | input | 1 | Trigger accepted |
| irq_clr_i | input | 1 | Interrupt clear |
| smp_valid_i | input | 1 | Sample valid |
| smp_data_i | input | SMP_W | Sample value |
| mem_we_o | output | 1 | Buffer write strobe |
| mem_addr_o | output | ADDR_W | Buffer word address |
| mem_wdata_o | output | 2*SMP_W | Packed sample pair |
| busy_o | output | 1 | Not idle; register loads are rejected |
| host_mem_en_o | output | 1 | Host buffer access allowed |
| unconfig_o | output | 1 | No register written since reset |
| irq_o | output | 1 | Capture complete |

## Verification
Two things can fall in the same cycle: a register load and the arm request. The bench provokes this by writing a new length in the very cycle that it arms. It judges the result by the number of words written, which must follow the new length and not the old one. A second overlap also gets attention: a sample arriving in the trigger cycle itself. Sweeps with this overlap turned on must produce the same packed data as if that sample had never been presented.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int PAIR    = 2;
  localparam int PAIR_LG = $clog2(PAIR);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARMED, ST_DELAY, ST_CAPT, ST_DONE
  } acq_state_e;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_LEN   = 2'd1,
    SEL_DLY   = 2'd2,
    SEL_RSVD  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/acq_regs.sv
module acq_regs
  import acq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 25,
  localparam int WD_W  = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [WD_W-1:0]   wdata_i,
  input  logic              idle_i,
  output logic [ADDR_W-1:0] start_o,
  output logic [CNT_W-1:0]  len_o,
  output logic [CNT_W-1:0]  dly_o,
  output logic              unconfig_o
);
  logic [ADDR_W-1:0] start_q;
  logic [CNT_W-1:0]  len_q, dly_q;
  logic              unconfig_q;
  logic              ld_start, ld_len, ld_dly;

  assign ld_start = we_i && idle_i && (reg_sel_e'(sel_i) == SEL_START);
  assign ld_len   = we_i && idle_i && (reg_sel_e'(sel_i) == SEL_LEN);
  assign ld_dly   = we_i && idle_i && (reg_sel_e'(sel_i) == SEL_DLY);

  // forward a same-cycle write so a concurrent arm sees it
  assign start_o = ld_start ? wdata_i[ADDR_W-1:0] : start_q;
  assign len_o   = ld_len   ? wdata_i[CNT_W-1:0]  : len_q;
  assign dly_o   = ld_dly   ? wdata_i[CNT_W-1:0]  : dly_q;
  assign unconfig_o = unconfig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q    <= '0;
      len_q      <= '0;
      dly_q      <= '0;
      unconfig_q <= 1'b1;
    end else begin
      if (ld_start) start_q <= wdata_i[ADDR_W-1:0];
      if (ld_len)   len_q   <= wdata_i[CNT_W-1:0];
      if (ld_dly)   dly_q   <= wdata_i[CNT_W-1:0];
      if (we_i)     unconfig_q <= 1'b0;
    end
  end
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int CNT_W = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             trig_i,
  input  logic             irq_clr_i,
  input  logic             smp_valid_i,
  input  logic             word_done_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [CNT_W-1:0] dly_i,
  output acq_state_e       state_o,
  output logic             go_o,
  output logic             take_o
);
  acq_state_e         st_q;
  logic [CNT_W-1:0]   words_q, dly_q;
  logic [PAIR_LG-1:0] dly_ph_q;
  logic [CNT_W:0]     len_up, dly_up;
  logic [CNT_W-1:0]   words_init, dly_init;
  acq_state_e         after_dly;

  assign len_up     = {1'b0, len_i} + (CNT_W+1)'(PAIR-1);
  assign dly_up     = {1'b0, dly_i} + (CNT_W+1)'(PAIR-1);
  assign words_init = CNT_W'(len_up >> PAIR_LG);
  assign dly_init   = CNT_W'(dly_up >> PAIR_LG);
  assign after_dly  = (words_q == '0) ? ST_DONE : ST_CAPT;

  assign state_o = st_q;
  assign go_o    = (st_q == ST_IDLE) && arm_i;
  assign take_o  = (st_q == ST_CAPT) && smp_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      words_q  <= '0;
      dly_q    <= '0;
      dly_ph_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (arm_i) begin
          st_q     <= ST_ARMED;
          words_q  <= words_init;
          dly_q    <= dly_init;
          dly_ph_q <= '0;
        end
        ST_ARMED: if (trig_i) begin
          st_q <= (dly_q != '0) ? ST_DELAY : after_dly;
        end
        ST_DELAY: if (smp_valid_i) begin
          if (dly_ph_q == PAIR_LG'(PAIR-1)) begin
            dly_ph_q <= '0;
            if (dly_q == CNT_W'(1)) st_q <= after_dly;
            dly_q <= dly_q - 1'b1;
          end else begin
            dly_ph_q <= dly_ph_q + 1'b1;
          end
        end
        ST_CAPT: if (word_done_i) begin
          if (words_q == CNT_W'(1)) st_q <= ST_DONE;
          words_q <= words_q - 1'b1;
        end
        ST_DONE: if (irq_clr_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/acq_pack.sv
module acq_pack
  import acq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SMP_W  = 8,
  localparam int WORD_W = SMP_W * PAIR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic              take_i,
  input  logic [SMP_W-1:0]  data_i,
  output logic              word_done_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o
);
  logic [PAIR_LG-1:0] idx_q;
  logic [SMP_W-1:0]   lane_q [PAIR-1];
  logic [WORD_W-1:0]  word;
  logic [ADDR_W-1:0]  addr_q;
  logic               last;

  assign last        = (idx_q == PAIR_LG'(PAIR-1));
  assign word_done_o = take_i && last;

  // earliest sample lands in the lowest lane
  for (genvar g = 0; g < PAIR; g++) begin : g_lane
    if (g == PAIR-1) begin : g_top
      assign word[g*SMP_W +: SMP_W] = data_i;
    end else begin : g_held
      assign word[g*SMP_W +: SMP_W] = lane_q[g];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                       lane_q[g] <= '0;
        else if (take_i && (idx_q == PAIR_LG'(g)))         lane_q[g] <= data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q       <= '0;
      addr_q      <= '0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o <= word_done_o;
      if (go_i) begin
        idx_q  <= '0;
        addr_q <= start_i;
      end else if (take_i) begin
        idx_q <= last ? '0 : idx_q + 1'b1;
        if (last) begin
          addr_q      <= addr_q + 1'b1;
          mem_addr_o  <= addr_q;
          mem_wdata_o <= word;
        end
      end
    end
  end
endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import acq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 25,
  parameter int SMP_W  = 8,
  localparam int WD_W   = (ADDR_W > CNT_W) ? ADDR_W : CNT_W,
  localparam int WORD_W = SMP_W * PAIR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [WD_W-1:0]   reg_wdata_i,
  input  logic              arm_i,
  input  logic              trig_i,
  input  logic              irq_clr_i,
  input  logic              smp_valid_i,
  input  logic [SMP_W-1:0]  smp_data_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              host_mem_en_o,
  output logic              unconfig_o,
  output logic              irq_o
);
  acq_state_e        state;
  logic              idle, go, take, word_done;
  logic [ADDR_W-1:0] start;
  logic [CNT_W-1:0]  len, dly;

  assign idle          = (state == ST_IDLE);
  assign busy_o        = !idle;
  assign host_mem_en_o = idle;
  assign irq_o         = (state == ST_DONE);

  acq_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .idle_i(idle), .start_o(start), .len_o(len), .dly_o(dly), .unconfig_o(unconfig_o)
  );

  acq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .arm_i, .trig_i, .irq_clr_i, .smp_valid_i,
    .word_done_i(word_done), .len_i(len), .dly_i(dly),
    .state_o(state), .go_o(go), .take_o(take)
  );

  acq_pack #(.ADDR_W(ADDR_W), .SMP_W(SMP_W)) u_pack (
    .clk_i, .rst_ni, .go_i(go), .start_i(start), .take_i(take), .data_i(smp_data_i),
    .word_done_o(word_done), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o)
  );
endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic              arm_i,
  input logic              irq_clr_i,
  input logic              smp_valid_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              busy_o,
  input logic              host_mem_en_o,
  input logic              unconfig_o,
  input logic              irq_o
);
  logic [ADDR_W-1:0] last_q;
  logic              have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      last_q <= '0;
    end else if (!busy_o) begin
      have_q <= 1'b0;
    end else if (mem_we_o) begin
      have_q <= 1'b1;
      last_q <= mem_addr_o;
    end
  end

  assert_unconfig_clr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> !unconfig_o);
  assert_unconfig_stay_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unconfig_o |=> !unconfig_o);
  assert_arm_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && arm_i) |=> busy_o);
  assert_we_after_smp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(smp_valid_i));
  assert_addr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && have_q) |-> (mem_addr_o == ADDR_W'(last_q + 1'b1)));
  assert_irq_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);
  assert_irq_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && irq_clr_i) |=> !busy_o);
  assert_no_host_we_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (!host_mem_en_o && busy_o));
endmodule

bind acq_seq acq_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .arm_i(arm_i),
  .irq_clr_i(irq_clr_i), .smp_valid_i(smp_valid_i), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .busy_o(busy_o), .host_mem_en_o(host_mem_en_o),
  .unconfig_o(unconfig_o), .irq_o(irq_o)
);

// File: tb/tb_acq_seq.sv
`timescale 1ns/1ps
module tb_acq_seq;
  localparam int ADDR_W = 6;
  localparam int CNT_W  = 8;
  localparam int SMP_W  = 8;
  localparam int AMOD   = 1 << ADDR_W;

  logic clk = 0, rst_ni = 0;
  logic reg_we_i = 0, arm_i = 0, trig_i = 0, irq_clr_i = 0, smp_valid_i = 0;
  logic [1:0] reg_sel_i = 0;
  logic [7:0] reg_wdata_i = 0;
  logic [7:0] smp_data_i = 0;
  logic mem_we_o, busy_o, host_mem_en_o, unconfig_o, irq_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [15:0] mem_wdata_o;

  int checks = 0, errors = 0, nwr = 0;
  bit done = 0;
  int cap_addr [64];
  int cap_data [64];

  always #4 clk = ~clk;

  acq_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SMP_W(SMP_W)) dut (
    .clk_i(clk), .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i, .arm_i, .trig_i,
    .irq_clr_i, .smp_valid_i, .smp_data_i, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .busy_o, .host_mem_en_o, .unconfig_o, .irq_o
  );

  always @(posedge clk) begin
    #2;
    if (mem_we_o && nwr < 64) begin
      cap_addr[nwr] = int'(mem_addr_o);
      cap_data[nwr] = int'(mem_wdata_o);
      nwr++;
    end
  end

  function automatic logic [7:0] sval(int i, int seed);
    return 8'(i * 29 + seed * 11 + 3);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int sel, int val);
    @(negedge clk); reg_we_i = 1; reg_sel_i = 2'(sel); reg_wdata_i = 8'(val);
    @(negedge clk); reg_we_i = 0;
  endtask

  task automatic program_regs(int start, int len, int dly);
    wr(0, start); wr(1, len); wr(2, dly);
  endtask

  task automatic arm();
    @(negedge clk); arm_i = 1;
    @(negedge clk); arm_i = 0;
    chk(busy_o == 1, "R3 arm from idle sets busy", int'(busy_o), 1);
  endtask

  task automatic clear();
    @(negedge clk); irq_clr_i = 1;
    @(negedge clk); irq_clr_i = 0;
    chk(!busy_o && host_mem_en_o && !irq_o, "R8 R9 idle after clear",
        int'(busy_o), 0);
  endtask

  task automatic finish_cap(int start, int len, int dly, bit gaps, bit trig_smp, int seed);
    int skip, nw, sidx, cyc;
    skip = ((dly + 1) / 2) * 2;
    nw   = (len + 1) / 2;
    sidx = 0; cyc = 0;
    nwr  = 0;
    @(negedge clk); trig_i = 1; smp_valid_i = trig_smp; smp_data_i = 8'hEE;
    @(negedge clk); trig_i = 0; smp_valid_i = 0;
    while (!irq_o && cyc < 400) begin
      smp_valid_i = gaps ? (cyc % 3 != 2) : 1'b1;
      smp_data_i  = sval(sidx, seed);
      if (smp_valid_i) sidx++;
      cyc++;
      @(negedge clk);
    end
    smp_valid_i = 0;
    chk(irq_o == 1, "R8 irq raised at completion", int'(irq_o), 1);
    chk(sidx == skip + 2 * nw, "R4 R6 samples consumed", sidx, skip + 2 * nw);
    chk(busy_o && !host_mem_en_o, "R9 no host access when done", int'(host_mem_en_o), 0);
    repeat (3) begin
      smp_valid_i = 1; smp_data_i = 8'h5A;
      @(negedge clk);
    end
    smp_valid_i = 0;
    @(negedge clk);
    chk(nwr == nw, "R6 word count", nwr, nw);
    chk(irq_o == 1, "R8 irq held while uncleared", int'(irq_o), 1);
    for (int k = 0; k < nw && k < nwr; k++) begin
      int ed, ea;
      ed = {sval(skip + 2*k + 1, seed), sval(skip + 2*k, seed)};
      ea = (start + k) % AMOD;
      chk(cap_data[k] == ed, "R5 packed word", cap_data[k], ed);
      chk(cap_addr[k] == ea, "R7 word address", cap_addr[k], ea);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy_o == 0, "R1 busy after reset", int'(busy_o), 0);
    chk(irq_o == 0, "R1 irq after reset", int'(irq_o), 0);
    chk(mem_we_o == 0, "R1 no write after reset", int'(mem_we_o), 0);
    chk(host_mem_en_o == 1, "R1 host access after reset", int'(host_mem_en_o), 1);
    chk(unconfig_o == 1, "R1 unconfigured after reset", int'(unconfig_o), 1);
    wr(0, 0);
    chk(unconfig_o == 0, "R1 unconfigured cleared by write", int'(unconfig_o), 0);

    // R3: trigger in idle and clear outside done are ignored; armed waits
    program_regs(20, 3, 2);
    @(negedge clk); trig_i = 1;
    @(negedge clk); trig_i = 0;
    chk(busy_o == 0, "R3 trigger ignored in idle", int'(busy_o), 0);
    nwr = 0;
    arm();
    repeat (5) begin
      smp_valid_i = 1; smp_data_i = 8'h11;
      @(negedge clk);
    end
    smp_valid_i = 0;
    irq_clr_i = 1; @(negedge clk); irq_clr_i = 0;
    @(negedge clk);
    chk(busy_o == 1 && nwr == 0, "R3 R8 armed holds without trigger", nwr, 0);
    finish_cap(20, 3, 2, 0, 0, 99);
    clear();

    // R2 R3: loads and arm while busy are ignored
    program_regs(10, 4, 0);
    arm();
    finish_cap(10, 4, 0, 0, 0, 5);
    wr(0, 40); wr(1, 2); wr(2, 6);
    @(negedge clk); arm_i = 1;
    @(negedge clk); arm_i = 0;
    chk(irq_o == 1, "R3 arm ignored while done", int'(irq_o), 1);
    clear();
    arm();
    finish_cap(10, 4, 0, 1, 0, 6);
    clear();

    // R3 collision: length load and arm in one cycle
    program_regs(5, 2, 0);
    @(negedge clk); reg_we_i = 1; reg_sel_i = 2'd1; reg_wdata_i = 8'd6; arm_i = 1;
    @(negedge clk); reg_we_i = 0; arm_i = 0;
    chk(busy_o == 1, "R3 collision arm accepted", int'(busy_o), 1);
    finish_cap(5, 6, 0, 0, 1, 12);
    clear();
    // R2: select 3 changes nothing
    wr(3, 1);
    arm();
    finish_cap(5, 6, 0, 1, 0, 13);
    clear();

    // R7 wrap
    program_regs(62, 8, 1);
    arm();
    finish_cap(62, 8, 1, 1, 1, 7);
    clear();

    // sweep length and delay
    for (int l = 0; l < 10; l++) begin
      for (int d = 0; d < 6; d++) begin
        int st;
        st = (l * 7 + d * 13) % AMOD;
        program_regs(st, l, d);
        arm();
        finish_cap(st, l, d, bit'((l + d) % 2), bit'(d % 2), l * 8 + d);
        clear();
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule